// File: doc/BRIEF.md
# Shared-Control Storage Bit Bank

This block holds eight single-bit storage elements that sit behind a group of four logic tables. The elements are split into two groups of four. The first group can act either as edge-triggered flip-flops or as level-sensitive latches. The second group can only be flip-flops. Each bit loads either its own table output or the bypass pin of its group. All eight bits share one clock, one clock enable and one set/reset line.

Every bit can be configured in three ways. It can be set to its select value or its clear value when the set/reset line is asserted. It has an initial value that it takes while the global reset is low. It also chooses where its data comes from. The bank as a whole is configured for clock polarity, for a synchronous or asynchronous set/reset response, and for latch mode. In latch mode the flip-flop-only group is disabled and shows its initial values.

The configuration inputs are static and may change only while `gsr_n` is low. Release of `gsr_n` is synchronised to the active clock edge inside the block. The bits therefore ignore the first two active edges after release.

Top module: `sse_bank`

## Requirements
- R1: In flop mode, on an active clock edge with `ce`=1 and `sr`=0, each bit `q[i]` takes its selected data value.
- R2: Data select: `cfg_byp_sel[i]`=1 selects `byp[i mod 4]`. When it is 0, bits 0..3 take `fn6[i]` and bits 4..7 take `fn5[i-4]`.
- R3: In flop mode, an active edge with `ce`=0 and `sr`=0 leaves every bit unchanged.
- R4: With `cfg_sr_sync`=1, `sr`=1 at an active edge sets `q[i]` to `cfg_sr_high[i]` even when `ce`=0. Before that edge nothing changes.
- R5: With `cfg_sr_sync`=0, `q[i]` becomes `cfg_sr_high[i]` as soon as `sr` rises, without waiting for a clock edge, and it keeps that value after `sr` falls.
- R6: With `cfg_clk_inv`=0 the active edge is the rising edge of `clk`. With `cfg_clk_inv`=1 it is the falling edge. The other edge has no effect.
- R7: With `cfg_latch`=1, bits 0..3 follow their data while the effective clock is low and `ce`=1. They hold while the effective clock is high or while `ce`=0.
- R8: With `cfg_latch`=1, bits 4..7 show `cfg_init_high[7:4]` whatever their data, `ce` and clock do.
- R9: While `gsr_n`=0, every `q[i]` equals `cfg_init_high[i]`, with no clock edge needed. After `gsr_n` rises, the first two active edges are ignored and the third one loads data.
- R10: `gsr_n`=0 overrides `sr`=1: the bits stay at their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; polarity set by `cfg_clk_inv` |
| gsr_n | input | 1 | Global set/reset, active low, asynchronous assert |
| ce | input | 1 | Shared clock enable, active high |
| sr | input | 1 | Shared set/reset, active high |
| fn6 | input | 4 | Main table outputs, data for bits 0..3 |
| fn5 | input | 4 | Secondary table outputs, data for bits 4..7 |
| byp | input | 4 | Bypass pins, one per group, each shared by bits g and g+4 |
| cfg_clk_inv | input | 1 | 1: falling edge is the active edge |
| cfg_latch | input | 1 | 1: bits 0..3 are latches, bits 4..7 are disabled |
| cfg_sr_sync | input | 1 | 1: synchronous set/reset, 0: asynchronous |
| cfg_byp_sel | input | 8 | Per-bit data source, 1 = bypass pin |
| cfg_sr_high | input | 8 | Per-bit value forced by `sr` |
| cfg_init_high | input | 8 | Per-bit value under `gsr_n` |
| q | output | 8 | Stored bits |

## Verification
A wrong priority between the global reset, `sr` and `ce` shows on `q` at the first active edge after the conflicting inputs are applied. A wrong release count shows as data loaded one edge early or late after `gsr_n` rises. A latch that is transparent in the wrong phase, or an asynchronous set/reset that waits for a clock, shows within half a clock period, so the bench samples in the middle of clock phases as well as after edges. A flip-flop-only bit that is not disabled in latch mode shows as soon as it loads data that differs from its initial value.

// File: rtl/sse_pkg.sv
package sse_pkg;

  localparam int unsigned SSE_GROUPS_DEFAULT = 4;
  localparam int unsigned SSE_RELEASE_STAGES = 2;

  // Data source choice for one storage bit.
  function automatic logic sse_pick_d(input logic use_byp, input logic byp_bit,
                                      input logic tbl_bit);
    return use_byp ? byp_bit : tbl_bit;
  endfunction

endpackage

// File: rtl/sse_rst_sync.sv
module sse_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sse_cell.sv
module sse_cell #(
  parameter bit LATCH_OK = 1'b0
) (
  input  logic eclk,
  input  logic rst_n,
  input  logic ce,
  input  logic sr,
  input  logic sr_sync,
  input  logic sr_val,
  input  logic init_val,
  input  logic latch_mode,
  input  logic d,
  output logic q
);

  logic sr_async;
  logic ff_d;
  logic ff_q;
  logic use_ff;

  assign sr_async = sr & ~sr_sync;
  assign use_ff   = ~latch_mode;

  // next-state of the flip-flop path: sr outranks ce
  always_comb begin
    if (sr) begin
      ff_d = sr_val;
    end else if (ce) begin
      ff_d = d;
    end else begin
      ff_d = ff_q;
    end
  end

  always_ff @(posedge eclk or negedge rst_n or posedge sr_async) begin
    if (!rst_n) begin
      ff_q <= init_val;
    end else if (sr_async) begin
      ff_q <= sr_val;
    end else begin
      ff_q <= ff_d;
    end
  end

  generate
    if (LATCH_OK) begin : g_latch
      logic lat_q;
      // open while effective clock is low; sr forces when async or while open
      always_latch begin
        if (!rst_n) begin
          lat_q = init_val;
        end else if (sr && (sr_async || !eclk)) begin
          lat_q = sr_val;
        end else if (!eclk && ce) begin
          lat_q = d;
        end
      end
      assign q = latch_mode ? lat_q : ff_q;
    end else begin : g_ff_only
      // disabled in latch mode: the bit presents its initial value
      assign q = latch_mode ? init_val : ff_q;
    end
  endgenerate

  // R1: enabled capture appears at the next active edge
  assert_capture_R1: assert property (@(posedge eclk) disable iff (!rst_n)
    (use_ff && ce && !sr) |=> (sr || latch_mode || q == $past(d)));

  // R3: no enable and no set/reset keeps the bit
  assert_hold_R3: assert property (@(posedge eclk) disable iff (!rst_n)
    (use_ff && !ce && !sr) |=> (sr || latch_mode || $stable(q)));

  // R4: synchronous set/reset lands on the edge regardless of ce
  assert_sync_sr_R4: assert property (@(posedge eclk) disable iff (!rst_n)
    (use_ff && sr && sr_sync) |=> (latch_mode || q == $past(sr_val)));

  // R5: asynchronous set/reset has already acted by any edge it is held over
  assert_async_sr_R5: assert property (@(posedge eclk) disable iff (!rst_n)
    (use_ff && sr && !sr_sync) |-> (q == sr_val));

endmodule

// File: rtl/sse_bank.sv
module sse_bank #(
  parameter int unsigned GROUPS = sse_pkg::SSE_GROUPS_DEFAULT
) (
  input  logic                  clk,
  input  logic                  gsr_n,
  input  logic                  ce,
  input  logic                  sr,
  input  logic [GROUPS-1:0]     fn6,
  input  logic [GROUPS-1:0]     fn5,
  input  logic [GROUPS-1:0]     byp,
  input  logic                  cfg_clk_inv,
  input  logic                  cfg_latch,
  input  logic                  cfg_sr_sync,
  input  logic [2*GROUPS-1:0]   cfg_byp_sel,
  input  logic [2*GROUPS-1:0]   cfg_sr_high,
  input  logic [2*GROUPS-1:0]   cfg_init_high,
  output logic [2*GROUPS-1:0]   q
);

  localparam int unsigned BITS = 2 * GROUPS;

  logic            eclk;
  logic            bank_rst_n;
  logic [BITS-1:0] d_sel;

  // programmable polarity folded into one effective clock
  assign eclk = clk ^ cfg_clk_inv;

  sse_rst_sync #(
    .STAGES (sse_pkg::SSE_RELEASE_STAGES)
  ) u_rel (
    .clk    (eclk),
    .arst_n (gsr_n),
    .rst_n  (bank_rst_n)
  );

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign d_sel[g]        = sse_pkg::sse_pick_d(cfg_byp_sel[g], byp[g], fn6[g]);
      assign d_sel[g+GROUPS] = sse_pkg::sse_pick_d(cfg_byp_sel[g+GROUPS], byp[g], fn5[g]);

      sse_cell #(.LATCH_OK(1'b1)) u_main (
        .eclk       (eclk),
        .rst_n      (bank_rst_n),
        .ce         (ce),
        .sr         (sr),
        .sr_sync    (cfg_sr_sync),
        .sr_val     (cfg_sr_high[g]),
        .init_val   (cfg_init_high[g]),
        .latch_mode (cfg_latch),
        .d          (d_sel[g]),
        .q          (q[g])
      );

      sse_cell #(.LATCH_OK(1'b0)) u_aux (
        .eclk       (eclk),
        .rst_n      (bank_rst_n),
        .ce         (ce),
        .sr         (sr),
        .sr_sync    (cfg_sr_sync),
        .sr_val     (cfg_sr_high[g+GROUPS]),
        .init_val   (cfg_init_high[g+GROUPS]),
        .latch_mode (cfg_latch),
        .d          (d_sel[g+GROUPS]),
        .q          (q[g+GROUPS])
      );
    end
  endgenerate

endmodule

// File: tb/tb_sse_bank.sv
`timescale 1ns/1ps
module tb_sse_bank;

  logic       clk;
  logic       gsr_n;
  logic       ce;
  logic       sr;
  logic [3:0] fn6;
  logic [3:0] fn5;
  logic [3:0] byp;
  logic       cfg_clk_inv;
  logic       cfg_latch;
  logic       cfg_sr_sync;
  logic [7:0] cfg_byp_sel;
  logic [7:0] cfg_sr_high;
  logic [7:0] cfg_init_high;
  logic [7:0] q;
  logic [7:0] exp_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sse_bank #(.GROUPS(4)) dut (
    .clk(clk), .gsr_n(gsr_n), .ce(ce), .sr(sr),
    .fn6(fn6), .fn5(fn5), .byp(byp),
    .cfg_clk_inv(cfg_clk_inv), .cfg_latch(cfg_latch), .cfg_sr_sync(cfg_sr_sync),
    .cfg_byp_sel(cfg_byp_sel), .cfg_sr_high(cfg_sr_high),
    .cfg_init_high(cfg_init_high), .q(q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] dvec(input logic [7:0] sel, input logic [3:0] b,
                                      input logic [3:0] f6, input logic [3:0] f5);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic t;
      t = (i < 4) ? f6[i] : f5[i-4];
      r[i] = sel[i] ? b[i % 4] : t;
    end
    return r;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] cur, input logic [7:0] dv,
                                     input logic c, input logic s, input logic [7:0] sv);
    if (s) return sv;
    if (c) return dv;
    return cur;
  endfunction

  task automatic active_edge();
    if (cfg_clk_inv) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic apply_reset(input bit inv, input bit lat, input bit sync,
                             input logic [7:0] s_hi, input logic [7:0] i_hi);
    logic [7:0] third;
    gsr_n = 1'b0;
    cfg_clk_inv = inv; cfg_latch = lat; cfg_sr_sync = sync;
    cfg_sr_high = s_hi; cfg_init_high = i_hi; cfg_byp_sel = 8'h00;
    ce = 1'b1; sr = 1'b1; byp = 4'h0;
    fn6 = ~i_hi[3:0]; fn5 = ~i_hi[7:4];
    #3;
    chk8("R9 bits at init while gsr_n low", q, i_hi);
    active_edge();
    chk8("R10 gsr_n outranks sr", q, i_hi);
    sr = 1'b0; gsr_n = 1'b1;
    active_edge();
    chk8("R9 first edge after release ignored", q, i_hi);
    active_edge();
    chk8("R9 second edge after release ignored", q, i_hi);
    active_edge();
    third = lat ? {i_hi[7:4], ~i_hi[3:0]} : ~i_hi;
    chk8("R9 third edge loads data", q, third);
    exp_q = third;
  endtask

  task automatic run_random(input int n);
    logic [7:0] nexp;
    cfg_byp_sel = 8'($urandom);
    for (int k = 0; k < n; k++) begin
      ce  = (($urandom % 4) != 0);
      sr  = (($urandom % 8) == 0);
      fn6 = 4'($urandom); fn5 = 4'($urandom); byp = 4'($urandom);
      nexp = nxt(exp_q, dvec(cfg_byp_sel, byp, fn6, fn5), ce, sr, cfg_sr_high);
      active_edge();
      chk8("R1/R2/R3/R4/R5/R6 random cycle", q, nexp);
      exp_q = nexp;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    gsr_n = 1'b0; ce = 1'b0; sr = 1'b0;
    fn6 = '0; fn5 = '0; byp = '0;
    cfg_clk_inv = 1'b0; cfg_latch = 1'b0; cfg_sr_sync = 1'b0;
    cfg_byp_sel = '0; cfg_sr_high = '0; cfg_init_high = '0;

    // synchronous set/reset waits for the edge and ignores ce (R4)
    apply_reset(1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C);
    ce = 1'b0; sr = 1'b1;
    #1;
    chk8("R4 sync sr waits for edge", q, 8'hC3);
    active_edge();
    chk8("R4 sync sr acts with ce low", q, 8'hA5);
    sr = 1'b0;
    active_edge();
    chk8("R3 hold with ce low", q, 8'hA5);

    // asynchronous set/reset acts at once (R5)
    apply_reset(1'b0, 1'b0, 1'b0, 8'h5A, 8'h0F);
    ce = 1'b0; sr = 1'b1;
    #0.5;
    chk8("R5 async sr before any edge", q, 8'h5A);
    sr = 1'b0;
    #0.5;
    chk8("R5 value kept after sr drops", q, 8'h5A);

    // inverted clock (R6)
    apply_reset(1'b1, 1'b0, 1'b0, 8'h00, 8'h99);
    ce = 1'b1; fn6 = 4'h9; fn5 = 4'h9;
    @(posedge clk); #1;
    chk8("R6 rising edge ignored when inverted", q, 8'h66);
    @(negedge clk); #1;
    chk8("R6 falling edge captures when inverted", q, 8'h99);

    // data source selection (R2)
    apply_reset(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    cfg_byp_sel = 8'hF0; byp = 4'hA; fn6 = 4'h5; fn5 = 4'h3;
    active_edge();
    chk8("R2 upper bits from bypass", q, 8'hA5);
    cfg_byp_sel = 8'h0F;
    active_edge();
    chk8("R2 lower bits from bypass", q, 8'h3A);

    // latch mode (R7, R8)
    apply_reset(1'b0, 1'b1, 1'b1, 8'hFF, 8'h50);
    ce = 1'b1; fn6 = 4'h6; fn5 = 4'hE;
    #0.5;
    chk8("R7 latch holds while clock high", q, 8'h5F);
    @(negedge clk); #0.5;
    chk8("R7 latch transparent while clock low", q, 8'h56);
    fn6 = 4'h3; #0.5;
    chk8("R7 latch follows new data", q, 8'h53);
    ce = 1'b0; fn6 = 4'hC; #0.5;
    chk8("R7 ce low closes latch", q, 8'h53);
    ce = 1'b1; #0.5;
    chk8("R7 latch reopens with ce", q, 8'h5C);
    @(posedge clk); #1;
    fn6 = 4'h1; #0.5;
    chk8("R7 latch holds after rising edge", q, 8'h5C);
    for (int k = 0; k < 8; k++) begin
      fn5 = 4'($urandom); byp = 4'($urandom);
      @(posedge clk); #1;
      chk8("R8 flop-only bits stay at init in latch mode", {q[7:4], 4'h0}, 8'h50);
    end

    // random phases mixing polarity and set/reset style
    for (int p = 0; p < 6; p++) begin
      apply_reset(p[0], 1'b0, 1'($urandom % 2), 8'($urandom), 8'($urandom));
      run_random(300);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule